// File: doc/BRIEF.md
# Single-Phase Multiplier-Based Digital PLL

This block locks a unit-amplitude local sinusoid onto a single-phase, signed sampled waveform, for instance a digitised grid voltage. It advances once for each sample strobe. A mixer multiplies the incoming sample by the local quadrature wave to form a phase error. A proportional-plus-integral filter turns that error into a correction. The nominal phase increment is added to the correction to give the frequency estimate. A phase accumulator then integrates the frequency estimate into an angle. A quarter-wave sine table turns the angle into an in-phase wave and a quarter-turn-lagging wave.

Angle and frequency are expressed in turns scaled by 2^PH_W. The frequency is the phase increment applied per sample, so the sample rate sets the time step. The gains and the nominal increment are runtime inputs. They are computed outside the block from the desired natural frequency, the damping and the rated input amplitude, with the amplitude dividing both gains. The mixer output carries a ripple at twice the input frequency with half the input amplitude. The loop bandwidth is the only thing that attenuates this ripple.

Top module: `spll_core`

## Requirements
- R1: A synchronous reset clears the angle, the frequency estimate and the integrator. Right after reset, `angle` and `freq_est` are 0, `sin_out` is 0 and `lag_out` is -32767.
- R2: In a cycle where `smp_vld` is low, `angle`, `freq_est`, `sin_out` and `lag_out` all keep their values, whatever `smp`, `kp`, `ki` and `nom_inc` do.
- R3: On a strobe, the new angle is (old angle + new `freq_est`) modulo 2^24.
- R4: `sin_out` equals round(32767·sin(2π·k/256)) within 2 LSB, where k is the top 8 bits of `angle` (2 quadrant bits followed by 6 table-index bits). `lag_out` is the same function evaluated at k-64 modulo 256, so it lags `sin_out` by a quarter turn.
- R5: The phase error is err = -(smp·lag_out), which is the sample multiplied by the local cosine. On a strobe, `freq_est` becomes nom_inc + floor(err·kp/2^24) + floor(acc/2^24), where acc is the integrator value before this update.
- R6: On a strobe, the integrator updates to acc + err·ki, limited to ±2^20·2^24. Because of this limit, the integrator's share of `freq_est` never exceeds 2^20 in magnitude.
- R7: `freq_est` is clamped to the range 0 to 2^24-1. A negative sum gives 0, and an oversize sum gives all ones.
- R8: Input: a sine of amplitude 16000 at the nominal increment 2^18, with kp=1638 and ki=16. After 2000 samples, the mean phase error over 64 samples is below 2% of 16000·32767/2. Over the same samples, the mean `freq_est` is within 1% of nominal, and `sin_out` correlates positively with the input.
- R9: With the input 2% above nominal frequency, the mean `freq_est` after 3000 samples is within 0.5% of the input increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe; the loop advances only when high |
| smp | input | SMP_W | Signed input sample |
| kp | input | GAIN_W | Proportional gain, unsigned, scaled by 2^-GAIN_SH |
| ki | input | GAIN_W | Integral gain, unsigned, scaled by 2^-GAIN_SH |
| nom_inc | input | PH_W | Nominal phase increment per sample |
| angle | output | PH_W | Estimated angle, unsigned, wraps every full turn |
| freq_est | output | PH_W | Estimated frequency as the phase increment per sample |
| sin_out | output | AMP_W | Unit sine of the angle, signed, full scale 32767 |
| lag_out | output | AMP_W | Sine lagging sin_out by a quarter turn |

## Verification
The bench sweeps all 256 table addresses, including the four quadrant boundaries. A wrong quadrant fold or sign there would show up as a mirrored or negated wave, or as a peak that misses full scale. Step-by-step arithmetic checks drive the integrator into both saturation limits and drive the frequency sum below zero and above full scale. A design that wraps instead of clamping would show a large frequency jump or a backward-running angle. Closed-loop runs at nominal frequency and 2% above it catch sign errors in the mixer, which would push the loop away from lock or toward the anti-phase point. They also catch frequency taken from the wrong tap, which would leave a steady offset.

// File: rtl/spll_pkg.sv
`timescale 1ns/1ps
package spll_pkg;

  localparam longint HALF_PI_Q30 = 64'sd1686629713;
  localparam longint ONE_Q30     = 64'sd1073741824;

  // Quarter-wave sine sample idx of 2^aw steps, scaled to 2^(amp_w-1)-1.
  // Odd Taylor series to x^9 evaluated in Horner form on Q30 integers.
  function automatic longint quarter_sine(input int idx, input int aw, input int amp_w);
    longint x, x2, t, s, amax, v;
    x    = (longint'(idx) * HALF_PI_Q30) >>> aw;
    x2   = (x * x) >>> 30;
    t    = ONE_Q30 - x2 / 72;
    t    = ONE_Q30 - ((x2 * t) >>> 30) / 42;
    t    = ONE_Q30 - ((x2 * t) >>> 30) / 20;
    t    = ONE_Q30 - ((x2 * t) >>> 30) / 6;
    s    = (x * t) >>> 30;
    amax = (64'sd1 <<< (amp_w - 1)) - 1;
    v    = (s * amax + (64'sd1 <<< 29)) >>> 30;
    if (v > amax) v = amax;
    if (v < 0) v = 0;
    return v;
  endfunction

endpackage

// File: rtl/spll_sincos.sv
`timescale 1ns/1ps
module spll_sincos #(
  parameter int PH_W   = 24,
  parameter int LUT_AW = 6,
  parameter int AMP_W  = 16
) (
  input  logic [PH_W-1:0]         angle,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] lag_o
);
  import spll_pkg::*;

  localparam int N = 1 << LUT_AW;
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W - 2);

  logic [AMP_W-2:0] lut [0:N];

  for (genvar g = 0; g <= N; g++) begin : g_lut
    localparam logic [AMP_W-2:0] VAL = (AMP_W-1)'(quarter_sine(g, LUT_AW, AMP_W));
    assign lut[g] = VAL;
  end

  logic [PH_W-1:0]         ph  [2];
  logic signed [AMP_W-1:0] val [2];

  assign ph[0] = angle;
  assign ph[1] = angle - QTR;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [LUT_AW:0]   addr;
    logic [AMP_W-2:0]  mag;
    logic              unused_low;

    assign quad = ph[c][PH_W-1 -: 2];
    assign idx  = ph[c][PH_W-3 -: LUT_AW];
    assign unused_low = ^ph[c][PH_W-LUT_AW-3:0];
    // odd quadrants read the table backwards
    assign addr = quad[0] ? ((LUT_AW+1)'(N) - {1'b0, idx}) : {1'b0, idx};
    assign mag  = lut[addr];
    // lower half turn is negative
    assign val[c] = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  assign sin_o = val[0];
  assign lag_o = val[1];

endmodule

// File: rtl/spll_loop_filter.sv
`timescale 1ns/1ps
module spll_loop_filter #(
  parameter int          SMP_W   = 16,
  parameter int          AMP_W   = 16,
  parameter int          GAIN_W  = 16,
  parameter int          PH_W    = 24,
  parameter int          GAIN_SH = 24,
  parameter int unsigned INT_LIM = 32'd1 << 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic signed [SMP_W-1:0] sample,
  input  logic signed [AMP_W-1:0] lag,
  input  logic [GAIN_W-1:0]       kp,
  input  logic [GAIN_W-1:0]       ki,
  input  logic [PH_W-1:0]         nom,
  output logic [PH_W-1:0]         freq_next,
  output logic [PH_W-1:0]         freq_q
);
  localparam int PROD_W = SMP_W + AMP_W;
  localparam int TERM_W = PROD_W + GAIN_W + 1;
  localparam int ACC_W  = (PH_W + GAIN_SH + 2 > TERM_W + 1) ? PH_W + GAIN_SH + 2 : TERM_W + 1;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic signed [ACC_W:0]   ACC_HI = $signed((ACC_W+1)'(INT_LIM)) <<< GAIN_SH;
  localparam logic signed [ACC_W:0]   ACC_LO = -ACC_HI;
  localparam logic signed [SUM_W-1:0] F_MAX  = SUM_W'({PH_W{1'b1}});

  // mixer: sample times local cosine (negated lagging wave)
  function automatic logic signed [PROD_W-1:0] mix(input logic signed [SMP_W-1:0] u,
                                                   input logic signed [AMP_W-1:0] l);
    return -(PROD_W'(u) * PROD_W'(l));
  endfunction

  function automatic logic signed [TERM_W-1:0] gain_mul(input logic signed [PROD_W-1:0] e,
                                                        input logic [GAIN_W-1:0] g);
    return TERM_W'(e) * TERM_W'($signed({1'b0, g}));
  endfunction

  logic signed [PROD_W-1:0] err;
  logic signed [TERM_W-1:0] p_full, i_full, p_term;
  logic signed [ACC_W-1:0]  acc_q, acc_next;
  logic signed [ACC_W:0]    acc_sum;
  logic signed [SUM_W-1:0]  f_sum;
  logic                     acc_hit_hi, acc_hit_lo, sum_neg, sum_hi;

  assign err    = mix(sample, lag);
  assign p_full = gain_mul(err, kp);
  assign i_full = gain_mul(err, ki);
  assign p_term = p_full >>> GAIN_SH;

  assign acc_sum    = (ACC_W+1)'(acc_q) + (ACC_W+1)'(i_full);
  assign acc_hit_hi = acc_sum > ACC_HI;
  assign acc_hit_lo = acc_sum < ACC_LO;
  assign acc_next   = acc_hit_hi ? ACC_W'(ACC_HI) :
                      acc_hit_lo ? ACC_W'(ACC_LO) : acc_sum[ACC_W-1:0];

  // frequency tap: nominal + proportional + integrator (pre-update)
  assign f_sum   = SUM_W'($signed({1'b0, nom})) + SUM_W'(p_term) + SUM_W'(acc_q >>> GAIN_SH);
  assign sum_neg = f_sum < 0;
  assign sum_hi  = f_sum > F_MAX;
  assign freq_next = sum_neg ? '0 : sum_hi ? '1 : f_sum[PH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      freq_q <= '0;
    end else if (strobe) begin
      acc_q  <= acc_next;
      freq_q <= freq_next;
    end
  end

  p_acc_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ((ACC_W+1)'(acc_q) <= ACC_HI) && ((ACC_W+1)'(acc_q) >= ACC_LO));
  p_acc_clip_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && acc_hit_hi) |=> ((ACC_W+1)'(acc_q) == ACC_HI));
  p_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe && sum_neg) |=> (freq_q == '0));
  p_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe && sum_hi) |=> (&freq_q));

endmodule

// File: rtl/spll_core.sv
`timescale 1ns/1ps
module spll_core #(
  parameter int          SMP_W   = 16,
  parameter int          AMP_W   = 16,
  parameter int          GAIN_W  = 16,
  parameter int          PH_W    = 24,
  parameter int          LUT_AW  = 6,
  parameter int          GAIN_SH = 24,
  parameter int unsigned INT_LIM = 32'd1 << 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [GAIN_W-1:0]       kp,
  input  logic [GAIN_W-1:0]       ki,
  input  logic [PH_W-1:0]         nom_inc,
  output logic [PH_W-1:0]         angle,
  output logic [PH_W-1:0]         freq_est,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] lag_out
);
  localparam logic signed [AMP_W-1:0] AMAX = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic [PH_W-1:0]         QTR  = PH_W'(1) << (PH_W - 2);

  logic [PH_W-1:0] angle_q, freq_next;

  spll_sincos #(.PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sincos (
    .angle (angle_q),
    .sin_o (sin_out),
    .lag_o (lag_out)
  );

  spll_loop_filter #(
    .SMP_W(SMP_W), .AMP_W(AMP_W), .GAIN_W(GAIN_W), .PH_W(PH_W),
    .GAIN_SH(GAIN_SH), .INT_LIM(INT_LIM)
  ) u_filt (
    .clk       (clk),
    .rst       (rst),
    .strobe    (smp_vld),
    .sample    (smp),
    .lag       (lag_out),
    .kp        (kp),
    .ki        (ki),
    .nom       (nom_inc),
    .freq_next (freq_next),
    .freq_q    (freq_est)
  );

  // phase accumulator, wraps modulo one turn
  always_ff @(posedge clk) begin
    if (rst) angle_q <= '0;
    else if (smp_vld) angle_q <= angle_q + freq_next;
  end

  assign angle = angle_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(angle_q) && $stable(freq_est)));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (angle_q == PH_W'($past(angle_q) + freq_est)));
  p_peak_r4: assert property (@(posedge clk) disable iff (rst)
    (angle_q == QTR) |-> (sin_out == AMAX && lag_out == '0));
  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    angle_q[PH_W-1] |-> (sin_out <= 0));
  p_lag_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (angle_q[PH_W-1:PH_W-2] == 2'b00) |-> (lag_out <= 0));

endmodule

// File: tb/spll_core_tb.sv
`timescale 1ns/1ps
module spll_core_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_vld = 1'b0;
  logic signed [15:0] smp = '0;
  logic [15:0]        kp = '0, ki = '0;
  logic [23:0]        nom_inc = '0;
  logic [23:0]        angle, freq_est;
  logic signed [15:0] sin_out, lag_out;

  int     checks = 0, errors = 0;
  bit     done = 1'b0;
  longint acc_m = 0;
  localparam longint LIM = longint'(1) <<< 44;
  localparam real    PI  = 3.14159265358979;

  spll_core u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp), .kp(kp), .ki(ki),
    .nom_inc(nom_inc), .angle(angle), .freq_est(freq_est),
    .sin_out(sin_out), .lag_out(lag_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic v, input logic signed [15:0] u);
    smp_vld = v;
    smp = u;
    @(posedge clk); #2;
    smp_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    rst = 1'b0;
    acc_m = 0;
  endtask

  function automatic int exp_sine(input int k);
    real r = 32767.0 * $sin(2.0 * PI * real'(k) / 256.0);
    return int'(r);
  endfunction

  // one strobe, predicted from the observed lagging wave and the rules
  task automatic step_chk(input logic signed [15:0] u, input string tag);
    longint e, s, fexp, acc_n;
    logic [23:0] a0, aexp;
    a0 = angle;
    e = -(longint'(u) * longint'(lag_out));
    s = longint'(nom_inc) + ((e * longint'(kp)) >>> 24) + (acc_m >>> 24);
    fexp = (s < 0) ? 0 : (s > 64'd16777215) ? 64'd16777215 : s;
    acc_n = acc_m + e * longint'(ki);
    if (acc_n > LIM) acc_n = LIM;
    if (acc_n < -LIM) acc_n = -LIM;
    aexp = a0 + 24'(fexp);
    pulse(1'b1, u);
    chk(freq_est == 24'(fexp), {tag, " freq"}, longint'(freq_est), fexp);
    chk(angle == aexp, "R3 angle step", longint'(angle), longint'(aexp));
    acc_m = acc_n;
  endtask

  task automatic lock_run(input real finc, input int nsmp, input bit gaps,
                          output real mean_err, output real mean_f, output real corr);
    real ph;
    longint se = 0, sf = 0, sc = 0;
    ph = 1.0;
    for (int n = 0; n < nsmp; n++) begin
      logic signed [15:0] u;
      u = 16'(int'(16000.0 * $sin(ph)));
      if (n >= nsmp - 64) begin
        se += -(longint'(u) * longint'(lag_out));
        sc += longint'(u) * longint'(sin_out);
      end
      pulse(1'b1, u);
      if (n >= nsmp - 64) sf += longint'(freq_est);
      if (gaps) pulse(1'b0, 16'sd0);
      ph = ph + 2.0 * PI * finc / 16777216.0;
    end
    mean_err = real'(se) / 64.0;
    mean_f   = real'(sf) / 64.0;
    corr     = real'(sc) / 64.0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    real me, mf, mc;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1 reset state
    chk(angle == 0, "R1 angle", longint'(angle), 0);
    chk(freq_est == 0, "R1 freq", longint'(freq_est), 0);
    chk(sin_out == 0, "R1 sin", longint'(sin_out), 0);
    chk(lag_out == -16'sd32767, "R1 lag", longint'(lag_out), -32767);

    // R4 / R3 sweep of every table address, open loop
    nom_inc = 24'd65536;
    for (int k = 0; k < 256; k++) begin
      int es, el;
      es = exp_sine(k);
      el = exp_sine((k + 192) % 256);
      chk(angle == 24'(k * 65536), "R3 sweep angle", longint'(angle), longint'(k * 65536));
      chk((sin_out - es <= 2) && (es - sin_out <= 2), "R4 sin", longint'(sin_out), es);
      chk((lag_out - el <= 2) && (el - lag_out <= 2), "R4 lag", longint'(lag_out), el);
      pulse(1'b1, 16'sd0);
    end
    chk(angle == 0, "R3 wrap", longint'(angle), 0);

    // R2 no strobe: nothing moves
    begin
      logic [23:0] a0, f0;
      logic signed [15:0] s0, l0;
      step_chk(16'sd0, "R2 prep");
      a0 = angle; f0 = freq_est; s0 = sin_out; l0 = lag_out;
      kp = 16'hffff; ki = 16'hffff; nom_inc = 24'h123456;
      for (int i = 0; i < 5; i++) pulse(1'b0, 16'sd30000);
      chk(angle == a0, "R2 angle", longint'(angle), longint'(a0));
      chk(freq_est == f0, "R2 freq", longint'(freq_est), longint'(f0));
      chk(sin_out == s0 && lag_out == l0, "R2 waves", longint'(sin_out), longint'(s0));
    end

    // R5 proportional path, several input patterns
    do_reset();
    kp = 16'd300; ki = 16'd0; nom_inc = 24'd262144;
    for (int i = 0; i < 40; i++) step_chk(16'((i * 7919) % 60001 - 30000), "R5");
    kp = 16'd65535;
    for (int i = 0; i < 20; i++) step_chk(16'((i % 2) ? 16'sd25000 : -16'sd11000), "R5 big");

    // R6 integrator with saturation both ways
    do_reset();
    kp = 16'd0; ki = 16'd65535; nom_inc = 24'd0;
    for (int i = 0; i < 12; i++) step_chk(16'sd20000, "R6 pos");
    for (int i = 0; i < 24; i++) step_chk(-16'sd20000, "R6 neg");
    ki = 16'd40;
    for (int i = 0; i < 20; i++) step_chk(16'((i * 3571) % 40001 - 20000), "R6 small");

    // R1 reset mid-run, then R7 clamps
    do_reset();
    chk(angle == 0 && freq_est == 0, "R1 rerun", longint'(angle), 0);
    kp = 16'd65535; ki = 16'd0; nom_inc = 24'd1000;
    step_chk(-16'sd30000, "R7 floor");
    chk(freq_est == 0, "R7 zero", longint'(freq_est), 0);
    chk(angle == 0, "R7 angle held", longint'(angle), 0);
    nom_inc = 24'd16776216;
    step_chk(16'sd30000, "R7 ceiling");
    chk(freq_est == 24'hffffff, "R7 max", longint'(freq_est), 64'd16777215);

    // R8 lock at nominal, strobe every other cycle
    do_reset();
    kp = 16'd1638; ki = 16'd16; nom_inc = 24'd262144;
    lock_run(262144.0, 2000, 1'b1, me, mf, mc);
    chk(me < 0.02 * 262136000.0 && me > -0.02 * 262136000.0, "R8 mean err",
        longint'(me), 0);
    chk(mf > 0.99 * 262144.0 && mf < 1.01 * 262144.0, "R8 mean freq",
        longint'(mf), 262144);
    chk(mc > 0.0, "R8 in phase", longint'(mc), 1);

    // R9 input 2% above nominal
    do_reset();
    lock_run(267387.0, 3000, 1'b0, me, mf, mc);
    chk(mf > 0.995 * 267387.0 && mf < 1.005 * 267387.0, "R9 mean freq",
        longint'(mf), 267387);
    chk(me < 0.02 * 262136000.0 && me > -0.02 * 262136000.0, "R9 mean err",
        longint'(me), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule